// File: doc/BRIEF.md
# Test-port instruction decode and data-register select

This block sits between a test access port state machine and the test data registers of a chip. It keeps the active instruction, which it loads from the instruction register's shift stage when the state machine signals an update. From that instruction it drives the mode controls of the external boundary chain and the pin-override controls. It also chooses which test data register is placed in the serial path between the serial test input and the serial test output.

Two of the data registers are inside the block. The first is a one-bit bypass register. The second is a 32-bit identification register, which captures either a fixed code built from parameters or a code supplied on a port. The serial output is registered on the falling test-clock edge. Its enable is raised only while the state machine is shifting data or instruction bits.

Top module: `jtag_dr_select`

## Requirements
- R1: On test reset (`trst_n` low) or while `tlr` is high at a rising edge, the active instruction becomes IDCODE (code 2) when `HAS_ID` is 1, and BYPASS (all ones) when `HAS_ID` is 0.
- R2: The active instruction takes the value of `ir_code` only at a rising edge where `update_ir` is high. A change on `ir_code` at any other time has no effect on the outputs.
- R3: The one-bit bypass register is the serial path for BYPASS (all ones), CLAMP (4), HIGHZ (5) and every code not listed in R4, R5 or R7 (7 to 14). It captures 0 on `capture_dr` and loads `tdi` on each `shift_dr` edge, so the first bit out is 0 and each later bit is the `tdi` value from one shift earlier.
- R4: Under IDCODE (code 2), `capture_dr` loads the identification register with {version[31:28], part[27:12], manufacturer[11:1], 1'b1}.
- R5: Under USERCODE (code 6), `capture_dr` loads the identification register with `user_code` unchanged.
- R6: While `shift_dr` is high, the identification register shifts toward bit 0 and `tdi` enters bit 31. After 32 shifts, the bits that were shifted in appear at the output.
- R7: EXTEST (0), SAMPLE/PRELOAD (1) and INTEST (3) raise `sel_bsr`, and the serial output then follows `bsr_tdo`.
- R8: `drive_pins` is high exactly for EXTEST and CLAMP. `drive_core` is high exactly for INTEST.
- R9: `pins_highz` is high exactly for HIGHZ.
- R10: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is high only after a falling edge where `shift_dr` or `shift_ir` is high. Under `shift_ir`, `tdo` takes `ir_tdo`. Both outputs are 0 during test reset.
- R11: With `HAS_ID` = 0, codes 2 and 6 decode as BYPASS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tlr | input | 1 | State machine is in test-logic-reset |
| update_ir | input | 1 | Update-IR strobe |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR state |
| shift_ir | input | 1 | Shift-IR state |
| tdi | input | 1 | Serial test data in |
| ir_tdo | input | 1 | Serial output of the instruction shift register |
| bsr_tdo | input | 1 | Serial output of the boundary chain |
| ir_code | input | IR_W | Instruction shift-stage contents |
| user_code | input | 32 | User-programmable identification code |
| tdo | output | 1 | Serial test data out |
| tdo_en | output | 1 | Output enable for tdo |
| sel_bsr | output | 1 | Boundary chain is in the serial path |
| drive_pins | output | 1 | Boundary hold rank drives the output pins |
| drive_core | output | 1 | Boundary hold rank drives the core inputs |
| pins_highz | output | 1 | Force every output pin to high impedance |

## Verification
The bench builds two instances with `IR_W` = 4: one with `HAS_ID` = 1 and one with `HAS_ID` = 0. Both receive the same stimulus. With a 4-bit instruction, all sixteen codes can be swept. For each code the bench checks every mode output and a 34-bit data scan. The scan is long enough to show the whole 32-bit capture and then the `tdi` bits that follow it. The second instance covers the reset default and the decode of codes 2 and 6 when there is no identification register.

// File: rtl/jtag_dr_select.sv
`timescale 1ns/1ps
module jtag_dr_select #(
  parameter int          IR_W    = 4,
  parameter bit          HAS_ID  = 1'b1,
  parameter logic [3:0]  ID_VER  = 4'h3,
  parameter logic [15:0] ID_PART = 16'hA51C,
  parameter logic [10:0] ID_MFR  = 11'h2B6
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tlr,
  input  logic            update_ir,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            shift_ir,
  input  logic            tdi,
  input  logic            ir_tdo,
  input  logic            bsr_tdo,
  input  logic [IR_W-1:0] ir_code,
  input  logic [31:0]     user_code,
  output logic            tdo,
  output logic            tdo_en,
  output logic            sel_bsr,
  output logic            drive_pins,
  output logic            drive_core,
  output logic            pins_highz
);
  localparam logic [IR_W-1:0] OP_EXTEST = IR_W'(0);
  localparam logic [IR_W-1:0] OP_SAMPLE = IR_W'(1);
  localparam logic [IR_W-1:0] OP_IDCODE = IR_W'(2);
  localparam logic [IR_W-1:0] OP_INTEST = IR_W'(3);
  localparam logic [IR_W-1:0] OP_CLAMP  = IR_W'(4);
  localparam logic [IR_W-1:0] OP_HIGHZ  = IR_W'(5);
  localparam logic [IR_W-1:0] OP_USER   = IR_W'(6);
  localparam logic [IR_W-1:0] OP_BYPASS = '1;
  localparam logic [IR_W-1:0] RST_CODE  = HAS_ID ? OP_IDCODE : OP_BYPASS;
  localparam logic [31:0]     ID_WORD   = {ID_VER, ID_PART, ID_MFR, 1'b1};

  logic [IR_W-1:0] active;
  logic            byp_q;
  logic [31:0]     id_q;

  wire is_idcode = HAS_ID && (active == OP_IDCODE);
  wire is_user   = HAS_ID && (active == OP_USER);
  wire id_sel    = is_idcode | is_user;
  wire byp_sel   = !id_sel && !sel_bsr;
  wire dr_out    = sel_bsr ? bsr_tdo : (id_sel ? id_q[0] : byp_q);

  assign sel_bsr    = (active == OP_EXTEST) | (active == OP_SAMPLE) | (active == OP_INTEST);
  assign drive_pins = (active == OP_EXTEST) | (active == OP_CLAMP);
  assign drive_core = (active == OP_INTEST);
  assign pins_highz = (active == OP_HIGHZ);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)        active <= RST_CODE;
    else if (tlr)       active <= RST_CODE;
    else if (update_ir) active <= ir_code;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q <= 1'b0;
      id_q  <= '0;
    end else begin
      if (byp_sel && capture_dr)    byp_q <= 1'b0;
      else if (byp_sel && shift_dr) byp_q <= tdi;
      if (id_sel && capture_dr)     id_q <= is_user ? user_code : ID_WORD;
      else if (id_sel && shift_dr)  id_q <= {tdi, id_q[31:1]};
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= shift_dr | shift_ir;
      if (shift_ir)      tdo <= ir_tdo;
      else if (shift_dr) tdo <= dr_out;
    end
  end
endmodule

module jtag_dr_select_chk #(
  parameter int IR_W   = 4,
  parameter bit HAS_ID = 1'b1
) (
  input logic            tck,
  input logic            trst_n,
  input logic            tlr,
  input logic            capture_dr,
  input logic            shift_dr,
  input logic            shift_ir,
  input logic            tdo_en,
  input logic            sel_bsr,
  input logic            drive_pins,
  input logic            drive_core,
  input logic            pins_highz,
  input logic            byp_sel,
  input logic            id_sel,
  input logic            is_idcode,
  input logic            byp_q,
  input logic [31:0]     id_q,
  input logic [IR_W-1:0] active
);
  localparam logic [IR_W-1:0] EXP_RST = HAS_ID ? IR_W'(2) : '1;

  assert_tlr_default_R1: assert property (@(posedge tck) disable iff (!trst_n)
    tlr |=> active == EXP_RST);
  assert_bypass_zero_R3: assert property (@(posedge tck) disable iff (!trst_n)
    (capture_dr && byp_sel) |=> !byp_q);
  assert_id_marker_R4: assert property (@(posedge tck) disable iff (!trst_n)
    (capture_dr && is_idcode) |=> id_q[0]);
  assert_id_shift_R6: assert property (@(posedge tck) disable iff (!trst_n)
    (shift_dr && id_sel && !capture_dr) |=> id_q[30:0] == $past(id_q[31:1]));
  assert_modes_exclusive_R8: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({pins_highz, drive_pins, drive_core}));
  assert_highz_no_chain_R9: assert property (@(posedge tck) disable iff (!trst_n)
    pins_highz |-> !sel_bsr);
  assert_enable_shift_R10: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en == (shift_dr || shift_ir));
endmodule

bind jtag_dr_select jtag_dr_select_chk #(.IR_W(IR_W), .HAS_ID(HAS_ID)) chk (
  .tck(tck), .trst_n(trst_n), .tlr(tlr), .capture_dr(capture_dr),
  .shift_dr(shift_dr), .shift_ir(shift_ir), .tdo_en(tdo_en), .sel_bsr(sel_bsr),
  .drive_pins(drive_pins), .drive_core(drive_core), .pins_highz(pins_highz),
  .byp_sel(byp_sel), .id_sel(id_sel), .is_idcode(is_idcode), .byp_q(byp_q),
  .id_q(id_q), .active(active)
);

// File: tb/jtag_dr_select_test.sv
`timescale 1ns/1ps
module jtag_dr_select_test;
  logic tck = 1'b0;
  logic trst_n = 1'b0, tlr = 1'b0, update_ir = 1'b0, capture_dr = 1'b0;
  logic shift_dr = 1'b0, shift_ir = 1'b0, tdi = 1'b0, ir_tdo = 1'b0, bsr_tdo = 1'b0;
  logic [3:0]  ir_code = 4'h0;
  logic [31:0] user_code = 32'h6D0B_42E8;
  logic tdo_a, en_a, bsr_a, pins_a, core_a, hz_a;
  logic tdo_b, en_b, bsr_b, pins_b, core_b, hz_b;
  int errors = 0, checks = 0;
  localparam logic [31:0] ID_EXP = {4'h3, 16'hA51C, 11'h2B6, 1'b1};

  always #2.5 tck = ~tck;

  jtag_dr_select #(.IR_W(4), .HAS_ID(1'b1)) uut (
    .tck(tck), .trst_n(trst_n), .tlr(tlr), .update_ir(update_ir), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .shift_ir(shift_ir), .tdi(tdi), .ir_tdo(ir_tdo), .bsr_tdo(bsr_tdo),
    .ir_code(ir_code), .user_code(user_code), .tdo(tdo_a), .tdo_en(en_a), .sel_bsr(bsr_a),
    .drive_pins(pins_a), .drive_core(core_a), .pins_highz(hz_a));

  jtag_dr_select #(.IR_W(4), .HAS_ID(1'b0)) uut_noid (
    .tck(tck), .trst_n(trst_n), .tlr(tlr), .update_ir(update_ir), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .shift_ir(shift_ir), .tdi(tdi), .ir_tdo(ir_tdo), .bsr_tdo(bsr_tdo),
    .ir_code(ir_code), .user_code(user_code), .tdo(tdo_b), .tdo_en(en_b), .sel_bsr(bsr_b),
    .drive_pins(pins_b), .drive_core(core_b), .pins_highz(hz_b));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // 0 boundary chain, 1 fixed id, 2 user id, 3 bypass
  function automatic int path_of(input logic [3:0] c, input bit has_id);
    if (c == 4'd0 || c == 4'd1 || c == 4'd3) return 0;
    if (has_id && c == 4'd2) return 1;
    if (has_id && c == 4'd6) return 2;
    return 3;
  endfunction

  function automatic logic [33:0] scan_exp(input int p, input logic [33:0] pat);
    case (p)
      0:       return ~pat;
      1:       return {pat[1:0], ID_EXP};
      2:       return {pat[1:0], user_code};
      default: return {pat[32:0], 1'b0};
    endcase
  endfunction

  task automatic cycle;
    @(posedge tck); #1;
  endtask

  task automatic scan(input logic [33:0] pat, output logic [33:0] oa, output logic [33:0] ob);
    capture_dr = 1'b1; cycle(); capture_dr = 1'b0;
    for (int i = 0; i < 34; i++) begin
      shift_dr = 1'b1; tdi = pat[i]; bsr_tdo = ~pat[i];
      @(negedge tck); #0.5;
      oa[i] = tdo_a; ob[i] = tdo_b;
      if (i == 0) check("R10 tdo_en in shift", {62'd0, en_a, en_b}, 64'd3);
      cycle();
    end
    shift_dr = 1'b0; tdi = 1'b0;
    cycle();
    check("R10 tdo_en idle", {62'd0, en_a, en_b}, 64'd0);
  endtask

  task automatic load_ir(input logic [3:0] c);
    ir_code = c; update_ir = 1'b1; cycle(); update_ir = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge tck);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [33:0] oa, ob, pat;
    repeat (3) @(posedge tck);
    #1;
    check("R10 reset outputs", {60'd0, tdo_a, en_a, tdo_b, en_b}, 64'd0);
    trst_n = 1'b1;
    cycle();

    // R1: default instruction after reset
    pat = 34'h2_9C3A_5E71;
    scan(pat, oa, ob);
    check("R1 reset default id", {30'd0, oa}, {30'd0, scan_exp(1, pat)});
    check("R1 R11 reset default no id", {30'd0, ob}, {30'd0, scan_exp(3, pat)});

    // R10: instruction shift path and falling-edge timing
    for (int i = 0; i < 4; i++) begin
      logic prev;
      prev = tdo_a;
      shift_ir = 1'b1; ir_tdo = i[0] ^ i[1] ^ 1'b1;
      #1;
      check("R10 tdo held before falling edge", {63'd0, tdo_a}, {63'd0, prev});
      @(negedge tck); #0.5;
      check("R10 ir_tdo on tdo", {62'd0, tdo_a, tdo_b}, {62'd0, ir_tdo, ir_tdo});
      cycle();
    end
    shift_ir = 1'b0;
    cycle();

    // sweep every code: R3 R4 R5 R6 R7 R8 R9 R11
    for (int c = 0; c < 16; c++) begin
      logic [3:0] cc;
      logic [3:0] m;
      cc = 4'(c);
      load_ir(cc);
      m = {cc == 4'd0 || cc == 4'd1 || cc == 4'd3, cc == 4'd0 || cc == 4'd4, cc == 4'd3, cc == 4'd5};
      check("R7 R8 R9 modes", {56'd0, bsr_a, pins_a, core_a, hz_a, bsr_b, pins_b, core_b, hz_b},
            {56'd0, m, m});
      pat = 34'h1_5A3C_96E1 ^ {30'd0, cc} ^ {cc, 30'd0};
      scan(pat, oa, ob);
      check("R3 R4 R5 R6 R7 scan", {30'd0, oa}, {30'd0, scan_exp(path_of(cc, 1'b1), pat)});
      check("R11 R3 scan no id", {30'd0, ob}, {30'd0, scan_exp(path_of(cc, 1'b0), pat)});
    end

    // R2: ir_code change without update has no effect
    load_ir(4'd1);
    ir_code = 4'd5;
    repeat (3) cycle();
    check("R2 no update no change", {62'd0, hz_a, bsr_a}, {62'd0, 1'b0, 1'b1});
    pat = 34'h0_F0F0_1234;
    scan(pat, oa, ob);
    check("R2 path kept", {30'd0, oa}, {30'd0, scan_exp(0, pat)});

    // R1: test-logic-reset restores default
    tlr = 1'b1; cycle(); tlr = 1'b0;
    check("R1 tlr clears modes", {62'd0, bsr_a, bsr_b}, 64'd0);
    pat = 34'h3_0001_8001;
    scan(pat, oa, ob);
    check("R1 tlr default id", {30'd0, oa}, {30'd0, scan_exp(1, pat)});
    check("R1 tlr default no id", {30'd0, ob}, {30'd0, scan_exp(3, pat)});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule